// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a three-wire configuration link. A host drives a serial clock, a write/read select and a data pin; the block keeps six 16-bit control words and presents them on a flat output bus, together with a decoded 3-bit line-driver gain code, to the rest of the control logic. All three link pins are resynchronised into the system clock domain, and serial-clock edges are detected there. The link must therefore toggle slowly compared with the system clock: each serial-clock phase should last at least four system clocks.

With the select high, the host sends a 19-bit frame, least significant bit first, one bit per falling serial-clock edge. The frame carries sixteen data bits and then three address bits. A twentieth falling edge, the commit edge, moves the holding buffer into the addressed word. When the host drops the select, the port switches to read mode. It drives the pin with the word named by the last committed frame, one bit per falling edge, starting with the least significant bit. The data pin is split into an input, an output and an output enable, so that the pad cell sits outside the block.

Top module: `cfg_serial_port`

## Requirements
- R1: During and after reset, the words hold these values: word 0 = 0x0002, word 1 = 0x0008, word 2 = 0x7800, word 3 = 0x7ACE, word 4 = 0x0000, word 5 = 0xC800. Word k occupies regs_o[16k+15:16k].
- R2: In write mode, each falling serial-clock edge shifts in one bit. Frame bit i (i = 0..18) comes from the i-th falling edge after the select rises. Bits 0..15 are data bits D0..D15 and bits 16..18 are address bits A0..A2. On the 20th falling edge, the data is written into word A.
- R3: Shifting alone never changes a word. After 19 edges the bus is unchanged, and it changes only after the commit edge.
- R4: A frame whose select drops before its commit edge is discarded. The words and the read source are left as they were.
- R5: A frame with address 6 or 7 changes no word. Any read that follows it drives zeros.
- R6: When the select falls, the port loads the read word and presents its bit 0 on sdio_o. Each later falling edge advances the pin by one bit, and after 16 edges the pin is 0.
- R7: A read returns the current value of the word addressed by the last committed frame. If no frame has been committed since reset, the read returns zeros.
- R8: sdio_oe_o is 0 during reset and while the select is high, and 1 in read mode.
- R9: pdrv_gain_o equals bits [4:2] of word 2, with bit 2 as its LSB.
- R10: Falling edges after the commit edge are ignored until the select rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| wr_sel_i | input | 1 | 1 = write mode, 0 = read mode |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial read data to the pad |
| sdio_oe_o | output | 1 | Pad output enable |
| regs_o | output | 96 | Six 16-bit words, word 0 in the low bits |
| pdrv_gain_o | output | 3 | Line-driver gain code (word 2 bits [4:2]) |

## Verification
Complete frames with random data and random addresses, including the two unused addresses, are each followed by a read. These show whether the address lands on the right word and whether the read source follows the last commit or goes to zeros. Frames cut short at random bit counts separate discard from partial update. Inspecting the bus after exactly 19 edges, and again after surplus edges past the commit, separates the commit edge from the shift edges. Reads taken straight out of reset, and reads that run past 16 edges, check the empty read source and the zero fill.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_DW      = 16;
  localparam int CFG_AW      = 3;
  localparam int CFG_NREG    = 6;
  localparam int GAIN_WORD   = 2;
  localparam int GAIN_LSB    = 2;
  localparam int GAIN_W      = 3;

  function automatic logic [CFG_DW-1:0] reset_word(input int idx);
    case (idx)
      0:       reset_word = 16'h0002;
      1:       reset_word = 16'h0008;
      2:       reset_word = 16'h7800;
      3:       reset_word = 16'h7ACE;
      5:       reset_word = 16'hC800;
      default: reset_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q, lvl_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= d_i;
      lvl_q  <= meta_q;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int DW = 16,
  parameter int AW = 3,
  localparam int FRAME = DW + AW,
  localparam int CW = $clog2(FRAME + 2)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_lvl_i,
  input  logic          wr_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sdi_i,
  output logic          commit_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME);
  localparam logic [CW-1:0] IDLE     = CW'(FRAME + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [FRAME-1:0] hold_q, hold_d;
  logic             commit_q, commit_d;

  always_comb begin
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    commit_d = 1'b0;
    if (wr_rise_i) begin
      cnt_d = '0;
    end else if (wr_lvl_i && sclk_fall_i) begin
      if (cnt_q < LAST_BIT) begin
        hold_d[cnt_q] = sdi_i;
        cnt_d         = cnt_q + 1'b1;
      end else if (cnt_q == LAST_BIT) begin
        commit_d = 1'b1;
        cnt_d    = IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= IDLE;
      hold_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      hold_q   <= hold_d;
      commit_q <= commit_d;
    end
  end

  assign commit_o = commit_q;
  assign data_o   = hold_q[DW-1:0];
  assign addr_o   = hold_q[FRAME-1:DW];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 3,
  parameter int NREG = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic [DW-1:0]    rd_word_o
);
  logic [DW-1:0] word_q [NREG];
  logic          src_ok_q, src_ok_d;
  logic [AW-1:0] src_q, src_d;
  logic          addr_ok;

  assign addr_ok = (int'(addr_i) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic          wen;
    logic [DW-1:0] nxt;
    assign wen = commit_i && (int'(addr_i) == g);
    assign nxt = wen ? data_i : word_q[g];
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= reset_word(g);
      else         word_q[g] <= nxt;
    end
    assign regs_o[g*DW +: DW] = word_q[g];
  end

  always_comb begin
    src_ok_d = src_ok_q;
    src_d    = src_q;
    if (commit_i) begin
      src_ok_d = addr_ok;
      src_d    = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      src_ok_q <= 1'b0;
      src_q    <= '0;
    end else begin
      src_ok_q <= src_ok_d;
      src_q    <= src_d;
    end
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (src_ok_q && (int'(src_q) == i)) rd_word_o = word_q[i];
    end
  end
endmodule

// File: rtl/cfg_read_tx.sv
module cfg_read_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_lvl_i,
  input  logic          wr_fall_i,
  input  logic          sclk_fall_i,
  input  logic [DW-1:0] word_i,
  output logic          sdo_o,
  output logic          oe_o
);
  logic [DW-1:0] sh_q, sh_d;
  logic          oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    oe_d = !wr_lvl_i;
    if (wr_fall_i)                     sh_d = word_i;
    else if (!wr_lvl_i && sclk_fall_i) sh_d = {1'b0, sh_q[DW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign sdo_o = sh_q[0];
  assign oe_o  = oe_q;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_pkg::*;
#(
  parameter int DATA_W   = CFG_DW,
  parameter int ADDR_W   = CFG_AW,
  parameter int NUM_REGS = CFG_NREG,
  localparam int FRAME = DATA_W + ADDR_W,
  localparam int CW    = $clog2(FRAME + 2)
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       wr_sel_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [GAIN_W-1:0]          pdrv_gain_o
);
  logic rst_m_q, rst_sn;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_m_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_sn  <= rst_m_q;
    end
  end

  logic [2:0] pins_s;
  logic       mode_lvl, sclk_lvl, sdi_lvl;
  logic       mode_prv, sclk_prv;
  logic       mode_rise, mode_fall, sclk_fall;

  cfg_sync #(.N(3)) i_sync (
    .clk(clk), .rst_ni(rst_sn),
    .d_i({sdio_i, sclk_i, wr_sel_i}), .q_o(pins_s)
  );
  assign {sdi_lvl, sclk_lvl, mode_lvl} = pins_s;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_prv <= 1'b0;
      sclk_prv <= 1'b0;
    end else begin
      mode_prv <= mode_lvl;
      sclk_prv <= sclk_lvl;
    end
  end

  assign mode_rise = mode_lvl & ~mode_prv;
  assign mode_fall = ~mode_lvl & mode_prv;
  assign sclk_fall = ~sclk_lvl & sclk_prv;

  logic              commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic [CW-1:0]     frm_cnt;
  logic [DATA_W-1:0] rd_word;

  cfg_frame_rx #(.DW(DATA_W), .AW(ADDR_W)) i_rx (
    .clk(clk), .rst_ni(rst_sn),
    .wr_lvl_i(mode_lvl), .wr_rise_i(mode_rise),
    .sclk_fall_i(sclk_fall), .sdi_i(sdi_lvl),
    .commit_o(commit), .addr_o(cm_addr), .data_o(cm_data), .cnt_o(frm_cnt)
  );

  cfg_reg_bank #(.DW(DATA_W), .AW(ADDR_W), .NREG(NUM_REGS)) i_bank (
    .clk(clk), .rst_ni(rst_sn),
    .commit_i(commit), .addr_i(cm_addr), .data_i(cm_data),
    .regs_o(regs_o), .rd_word_o(rd_word)
  );

  cfg_read_tx #(.DW(DATA_W)) i_tx (
    .clk(clk), .rst_ni(rst_sn),
    .wr_lvl_i(mode_lvl), .wr_fall_i(mode_fall),
    .sclk_fall_i(sclk_fall), .word_i(rd_word),
    .sdo_o(sdio_o), .oe_o(sdio_oe_o)
  );

  assign pdrv_gain_o = regs_o[GAIN_WORD*DATA_W + GAIN_LSB +: GAIN_W];
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 6,
  localparam int FRAME = DATA_W + ADDR_W,
  localparam int CW    = $clog2(FRAME + 2)
) (
  input logic                       clk,
  input logic                       rst_ni,
  input logic                       rst_sn,
  input logic                       commit,
  input logic [ADDR_W-1:0]          cm_addr,
  input logic [DATA_W-1:0]          cm_data,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic                       oe,
  input logic                       mode_lvl,
  input logic [CW-1:0]              cnt
);
  int unsigned widx;
  assign widx = int'(cm_addr) * DATA_W;

  // R3
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !commit |=> $stable(regs));

  // R2
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (commit && int'(cm_addr) < NUM_REGS) |=> regs[$past(widx) +: DATA_W] == $past(cm_data));

  // R5
  bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (commit && int'(cm_addr) >= NUM_REGS) |=> $stable(regs));

  // R8
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mode_lvl |=> !oe);

  // R10
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    int'(cnt) <= FRAME + 1);

  // R8
  always @(negedge clk) begin
    if (!rst_ni) begin
      oe_in_reset_chk: assert (!oe);
    end
  end
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) i_chk (
  .clk(clk), .rst_ni(rst_ni), .rst_sn(rst_sn), .commit(commit),
  .cm_addr(cm_addr), .cm_data(cm_data), .regs(regs_o), .oe(sdio_oe_o),
  .mode_lvl(mode_lvl), .cnt(frm_cnt)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int DW = 16;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rst_ni, sclk, wsel, sdi;
  logic sdo, oe;
  logic [NR*DW-1:0] regs;
  logic [2:0] gain;

  always #2 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_ni(rst_ni), .sclk_i(sclk), .wr_sel_i(wsel), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .regs_o(regs), .pdrv_gain_o(gain)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [NR];
  bit lv;
  int la;

  function automatic logic [DW-1:0] rst_val(int i);
    case (i)
      0: return 16'h0002;
      1: return 16'h0008;
      2: return 16'h7800;
      3: return 16'h7ACE;
      5: return 16'hC800;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [NR*DW-1:0] model_bus();
    logic [NR*DW-1:0] b;
    for (int i = 0; i < NR; i++) b[i*DW +: DW] = model[i];
    return b;
  endfunction

  function automatic logic [DW-1:0] read_exp();
    return lv ? model[la] : '0;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_edge(input logic b);
    sdi = b; sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic start_write();
    wsel = 1'b0; wait_n(8);
    wsel = 1'b1; wait_n(8);
    check("R8 oe in write", oe, 1'b0);
  endtask

  // shift nbits of the frame; optionally send the commit edge
  task automatic send(input logic [2:0] a, input logic [DW-1:0] d, input int nbits, input bit cm);
    start_write();
    for (int i = 0; i < nbits; i++) fall_edge(i < DW ? d[i] : a[i-DW]);
    if (cm) begin
      fall_edge(1'b0);
      if (nbits == DW + 3) begin
        if (int'(a) < NR) begin model[a] = d; lv = 1; la = int'(a); end
        else lv = 0;
      end
    end
  endtask

  task automatic read_back(input string req);
    logic [DW-1:0] e;
    e = read_exp();
    wsel = 1'b0; wait_n(8);
    check("R8 oe in read", oe, 1'b1);
    for (int i = 0; i < DW; i++) begin
      check(req, sdo, e[i]);
      fall_edge(1'b0);
    end
    check("R6 zero fill", sdo, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0; sclk = 1'b0; wsel = 1'b0; sdi = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = rst_val(i);
    lv = 0; la = 0;
    wait_n(5);
    check("R8 oe during reset", oe, 1'b0);
    check("R1 reset words", regs, model_bus());
    rst_ni = 1'b1; wait_n(10);
    check("R1 words after reset", regs, model_bus());
    check("R9 gain at reset", gain, 3'd0);

    // R7: nothing committed yet -> zeros
    read_back("R7 empty read");

    // R3: 19 bits shifted, no commit yet
    send(3'd2, 16'hA5D4, 19, 0);
    check("R3 no change before commit", regs, model_bus());
    fall_edge(1'b0);
    model[2] = 16'hA5D4; lv = 1; la = 2;
    check("R2 commit word 2", regs, model_bus());
    check("R9 gain code", gain, 3'b101);
    // R10: extra edges after commit
    for (int i = 0; i < 5; i++) fall_edge(1'b1);
    check("R10 extra edges ignored", regs, model_bus());
    read_back("R6 read word 2");

    // R4: aborted frame
    send(3'd0, 16'h1234, 12, 0);
    check("R4 abort no change", regs, model_bus());
    read_back("R4 read source kept");

    // R5: bad address
    send(3'd7, 16'hFFFF, 19, 1);
    wait_n(4);
    check("R5 addr 7 ignored", regs, model_bus());
    read_back("R5 read zeros");
    send(3'd5, 16'h0F0F, 19, 1);
    read_back("R7 read word 5");

    for (int it = 0; it < 40; it++) begin
      logic [2:0] a;
      logic [DW-1:0] d;
      int nb;
      a = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      nb = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 18)) : 19;
      send(a, d, nb, nb == 19);
      wait_n(4);
      check(nb == 19 ? "R2 random frame" : "R4 random abort", regs, model_bus());
      check("R9 gain follows word 2", gain, model[2][4:2]);
      read_back("R7 random read");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule